// File: doc/BRIEF.md
# Serial Frame Transmitter

This block turns one data word at a time into an asynchronous serial frame on a single output line. A frame is a low start bit, then 5 to 9 data bits with the least significant bit first, then an optional parity bit, then a high stop period of one, one and a half or two bit times. Between frames the line rests high. A clock divider sets the bit rate, so common rates such as 9600 or 115200 baud can be produced from the system clock.

A producer offers a word with a valid/ready handshake. The accepted word and its format settings go into a single holding slot. The shifter takes them from that slot as soon as the line is free, so a second word can wait while the first one is on the line. Frames then follow each other with no idle gap. Two status outputs are provided: `in_ready` shows that the holding slot can take a word, and `busy` shows that a frame is still on the line.

Top module: `serial_tx`

## Requirements
- R1: After reset, `tx` is 1, `busy` is 0 and `in_ready` is 1. Whenever no frame is being sent, `tx` stays at 1.
- R2: A frame starts with one bit time at 0. The data bits follow, least significant bit first. `cfg_len` selects the data length: codes 0 to 4 give 5 to 9 bits, and codes 5 to 7 give 9 bits.
- R3: `cfg_par` selects the parity bit, which is sent right after the last data bit. The codes are 0 none, 1 even, 2 odd, 3 mark (always 1) and 4 space (always 0); codes 5 to 7 mean none. Even parity makes the number of ones in the data bits plus the parity bit even. Odd parity makes that number odd.
- R4: `cfg_stop` selects the length of the stop period, during which the line is 1: code 0 gives 1 bit time, code 1 gives 1.5 bit times, and codes 2 and 3 give 2 bit times. When the stop period ends, `busy` falls.
- R5: One bit time is 2*(`cfg_half`+1) clock cycles, and a half bit time is `cfg_half`+1 cycles. `tx` stays constant inside each bit.
- R6: A word is accepted on a clock edge where `in_valid` and `in_ready` are both 1. After that edge `in_ready` is 0 until the shifter takes the word. A word that waits in the slot goes on the line right after the last stop cycle of the frame before it, with no idle cycle between the two frames.
- R7: `busy` is 1 during every cycle from the first start-bit cycle to the last stop cycle. A frame starts on the edge after the word is accepted, or right after the frame that is already on the line.
- R8: The data and all configuration inputs are sampled when the word is accepted. Changes to them afterwards do not alter that word's frame.
- R9: Data bits above the selected length are neither sent nor counted for parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The holding slot is free |
| in_data | input | 9 | Word to send; only the low bits up to the selected length are used |
| cfg_len | input | 3 | Data length code |
| cfg_par | input | 3 | Parity mode code |
| cfg_stop | input | 2 | Stop length code |
| cfg_half | input | DIV_W | Half-bit period in clock cycles, minus one |
| tx | output | 1 | Serial line output |
| busy | output | 1 | A frame is on the line |

## Verification
The bench keeps the default divider width but sets `cfg_half` to values between 0 and 4. With these values a full 9-bit frame with parity and a two-bit stop period lasts at most 130 cycles. All length, parity and stop codes can therefore be run, including the unused codes. Small divisors also make the half-bit boundary of the 1.5-bit stop period, and frames sent back to back, short enough to compare cycle by cycle against the behavioural line model.

// File: rtl/serial_tx.sv
module serial_tx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [8:0]       in_data,
  input  logic [2:0]       cfg_len,
  input  logic [2:0]       cfg_par,
  input  logic [1:0]       cfg_stop,
  input  logic [DIV_W-1:0] cfg_half,
  output logic             tx,
  output logic             busy
);
  localparam int FW = 12;
  localparam int HW = 5;

  logic [3:0]       nbits;
  logic [8:0]       dmask;
  logic             par_en, pbit;
  logic [FW-1:0]    fr;
  logic [HW-1:0]    halves;

  logic             hold_v;
  logic [FW-1:0]    hold_fr;
  logic [HW-1:0]    hold_h;
  logic [DIV_W-1:0] hold_div;

  logic [FW-1:0]    sh;
  logic [HW-1:0]    left;
  logic [DIV_W-1:0] hcnt, div_r;
  logic             phase;

  assign nbits  = (cfg_len > 3'd4) ? 4'd9 : 4'd5 + {1'b0, cfg_len};
  assign dmask  = in_data & 9'((10'd1 << nbits) - 10'd1);
  assign par_en = (cfg_par >= 3'd1) && (cfg_par <= 3'd4);

  always_comb begin
    case (cfg_par)
      3'd1:    pbit = ^dmask;
      3'd2:    pbit = ~^dmask;
      3'd3:    pbit = 1'b1;
      default: pbit = 1'b0;
    endcase
    fr    = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < 9; i++)
      if (i < int'(nbits)) fr[i+1] = dmask[i];
    if (par_en) fr[nbits+4'd1] = pbit;
  end

  assign halves = HW'(2 * (1 + nbits + par_en)) +
                  ((cfg_stop == 2'd0) ? HW'(2) : (cfg_stop == 2'd1) ? HW'(3) : HW'(4));

  wire accept    = in_valid && in_ready;
  wire half_tick = busy && (hcnt == '0);
  wire load      = hold_v && (!busy || (half_tick && left == HW'(1)));

  assign in_ready = !hold_v;
  assign tx       = !busy || sh[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v   <= 1'b0;
      hold_fr  <= '1;
      hold_h   <= '0;
      hold_div <= '0;
    end else if (accept) begin
      hold_v   <= 1'b1;
      hold_fr  <= fr;
      hold_h   <= halves;
      hold_div <= cfg_half;
    end else if (load) begin
      hold_v   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      sh    <= '1;
      left  <= '0;
      hcnt  <= '0;
      div_r <= '0;
      phase <= 1'b0;
    end else if (load) begin
      busy  <= 1'b1;
      sh    <= hold_fr;
      left  <= hold_h;
      hcnt  <= hold_div;
      div_r <= hold_div;
      phase <= 1'b0;
    end else if (half_tick) begin
      hcnt  <= div_r;
      left  <= left - HW'(1);
      phase <= !phase;
      if (phase) sh <= {1'b1, sh[FW-1:1]};
      if (left == HW'(1)) busy <= 1'b0;
    end else if (busy) begin
      hcnt  <= hcnt - DIV_W'(1);
    end
  end

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tx);
  a_r6_slot_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  a_r5_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hcnt != '0) |=> $stable(tx));
  a_r4_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tx));
  a_r7_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !in_ready) |=> busy);
endmodule

// File: tb/serial_tx_bench.sv
module serial_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [8:0]  in_data = '0;
  logic [2:0]  cfg_len = '0;
  logic [2:0]  cfg_par = '0;
  logic [1:0]  cfg_stop = '0;
  logic [15:0] cfg_half = '0;
  logic        in_ready, tx, busy;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string cur_req = "R1";

  int line_q[$];
  int hold_q[$];
  bit m_hold_v = 1'b0;

  always #4 clk = !clk;

  serial_tx u_serial_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_len(cfg_len), .cfg_par(cfg_par),
    .cfg_stop(cfg_stop), .cfg_half(cfg_half), .tx(tx), .busy(busy)
  );

  task automatic build_frame();
    int n, d, ones, pen, pb, stoph;
    n = (cfg_len > 4) ? 9 : 5 + int'(cfg_len);
    d = int'(cfg_half) + 1;
    hold_q.delete();
    ones = 0;
    for (int k = 0; k < 2 * d; k++) hold_q.push_back(0);
    for (int b = 0; b < n; b++) begin
      ones += int'(in_data[b]);
      for (int k = 0; k < 2 * d; k++) hold_q.push_back(int'(in_data[b]));
    end
    pen = 1;
    case (cfg_par)
      3'd1: pb = ones % 2;
      3'd2: pb = 1 - ones % 2;
      3'd3: pb = 1;
      3'd4: pb = 0;
      default: begin pb = 0; pen = 0; end
    endcase
    if (pen == 1)
      for (int k = 0; k < 2 * d; k++) hold_q.push_back(pb);
    stoph = (cfg_stop == 2'd0) ? 2 : (cfg_stop == 2'd1) ? 3 : 4;
    for (int k = 0; k < stoph * d; k++) hold_q.push_back(1);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      line_q.delete();
      m_hold_v <= 1'b0;
    end else begin
      automatic bit acc = in_valid && !m_hold_v;
      if (line_q.size() > 0) void'(line_q.pop_front());
      if (line_q.size() == 0 && m_hold_v) begin
        foreach (hold_q[i]) line_q.push_back(hold_q[i]);
        m_hold_v <= 1'b0;
      end
      if (acc) begin
        build_frame();
        m_hold_v <= 1'b1;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(cur_req, "tx", int'(tx), line_q.size() > 0 ? line_q[0] : 1);
      check("R7", "busy", int'(busy), int'(line_q.size() > 0));
      check("R6", "in_ready", int'(in_ready), int'(!m_hold_v));
    end
    if (cyc == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic send(int d, int len, int par, int stop, int half);
    @(negedge clk);
    in_data = 9'(d); cfg_len = 3'(len); cfg_par = 3'(par);
    cfg_stop = 2'(stop); cfg_half = 16'(half); in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy || !in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset tx", int'(tx), 1);
    check("R1", "reset busy", int'(busy), 0);
    check("R1", "reset in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    cur_req = "R2";
    for (int l = 0; l < 8; l++) begin
      send(9'h0B5 ^ (l * 37), l, 0, 0, 1);
      wait_idle();
    end

    cur_req = "R3";
    for (int p = 0; p < 8; p++) begin
      send(9'h053, 3, p, 0, 1);
      wait_idle();
      send(9'h1A3, 4, p, 2, 0);
      wait_idle();
    end

    cur_req = "R4";
    for (int s = 0; s < 4; s++) begin
      send(9'h0F0, 3, 1, s, 1);
      wait_idle();
      send(9'h00F, 0, 0, s, 2);
      wait_idle();
    end

    cur_req = "R5";
    for (int h = 0; h < 5; h++) begin
      send(9'h0A5, 3, 2, 1, h);
      wait_idle();
    end

    cur_req = "R6";
    send(9'h031, 3, 0, 1, 0);
    send(9'h1C4, 4, 1, 0, 1);
    send(9'h07E, 2, 3, 2, 0);
    send(9'h100, 4, 2, 1, 2);
    wait_idle();

    cur_req = "R8";
    send(9'h0C3, 3, 1, 0, 1);
    @(negedge clk);
    cfg_len = 3'd0; cfg_par = 3'd3; cfg_stop = 2'd2; cfg_half = 16'd4; in_data = 9'h1FF;
    send(9'h066, 1, 2, 1, 0);
    @(negedge clk);
    cfg_len = 3'd4; cfg_par = 3'd0; cfg_stop = 2'd0; cfg_half = 16'd3; in_data = 9'h000;
    wait_idle();

    cur_req = "R9";
    send(9'h1E0, 0, 1, 0, 1);
    wait_idle();
    send(9'h180, 1, 2, 0, 0);
    wait_idle();
    send(9'h1FF, 0, 1, 1, 0);
    wait_idle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule